// File: doc/BRIEF.md
# Composite Sync and Display Window Timebase

This block is the line and field timebase of a 625-line text display with a 64 µs line. It produces an active-low composite sync on `csync_n`. That sync is built from line pulses, half-line equalizing pulses and broad field pulses. It also produces a frame-parity flag on `odd_even` and a display-enable window `disp_en` that frames the 40-column, 250-row text area. All timing is counted in ticks of a strobe `tick`, which is derived from the pixel clock. `LINE_TICKS` ticks make one line. Every pulse edge is the nearest whole tick to its nominal time, computed as round(t_µs × LINE_TICKS / 64) when the design is elaborated.

The timing is organised in half-lines. A state machine walks each field through five states. ST_IDLE waits while external sync is selected. ST_PRE_EQ holds five equalizing half-lines. ST_BROAD holds five broad-pulse half-lines. ST_POST_EQ holds five more equalizing half-lines. ST_ACTIVE holds the remaining half-lines of the field, which carry line pulses. The state machine makes these transitions:
- IDLE to PRE_EQ on any clock edge where the mode is not external sync.
- PRE_EQ to BROAD, BROAD to POST_EQ, and POST_EQ to ACTIVE at the end of the fifth half-line in each state.
- ACTIVE to PRE_EQ at the end of a field.
- ACTIVE to IDLE at the end of a frame when external sync is selected.

The 2-bit `mode_in` chooses the field lengths. Its value is taken only when a frame begins.

Top module: `csg_timebase`

## Requirements
- R1: While `rst_n` is low, `csync_n` is 1, `disp_en` is 0 and `odd_even` is 0, whatever `tick` does.
- R2: In ACTIVE half-lines, the first half of every line is low for round(4.66 µs) ticks from its start (28 of 384, or 5 of 64). The second half of the line carries no pulse.
- R3: Five equalizing half-lines come before the broad block and five come after it. Each is low for round(2.33 µs) ticks from the start of the half-line (14 of 384, or 2 of 64).
- R4: The five broad half-lines are each low for round(27.33 µs) ticks from their start (164 of 384, or 27 of 64).
- R5: Field lengths depend on the mode:
  - Mode 2'b00: two fields of 625 half-lines each, so the second field begins mid-line.
  - Mode 2'b01: 624 half-lines, then 626.
  - Mode 2'b10: 624 half-lines, then 624.
  - In every mode a frame begins at a line start with its first equalizing half-line.
- R6: Mode 2'b11 (external sync) lets the current frame finish and then idles, with `csync_n`=1, `disp_en`=0 and `odd_even`=0. The first clock edge that sees another mode starts a new frame at tick position 0, with or without `tick`.
- R7: A change of `mode_in` in the middle of a frame has no effect until the next frame begins.
- R8: `odd_even` is 0 in the first frame after a start and toggles at every frame boundary. `parity_off`=1 forces it to 0 at once, and the underlying parity is kept.
- R9: `disp_en` is 1 only at line offsets from round(16.67 µs) up to, but not including, round(56.67 µs): 100 to 339 of 384, or 17 to 56 of 64. It applies only on frame lines 42 to 291 and 355 to 604, where line 1 is the first line of the frame.
- R10: `sync_oe`=0 holds `csync_n` at 1 while the timing keeps running.
- R11: The counters advance only on clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe, one tick per pulse |
| mode_in | input | 2 | Field mode: 00 interlaced, 01 text, 10 terminal, 11 external sync |
| sync_oe | input | 1 | Composite sync driver enable |
| parity_off | input | 1 | Forces `odd_even` low |
| csync_n | output | 1 | Active-low composite sync |
| disp_en | output | 1 | Text display window |
| odd_even | output | 1 | Frame parity, high on even frames |

## Verification
The bench targets the half-line shift of the second interlaced field. A design that counted whole lines there would put the equalizing pulse at the wrong instant and would misplace every following broad pulse by 32 ticks. The bench also checks the long and short fields of text mode against interlaced mode. A design with the field lengths swapped or shared would place the broad pulses of the second field at the wrong ticks.

A mid-frame mode change and a request for external sync are applied while a frame is running. A design that reacted at once would cut the frame short. Tick gaps and windows with the driver or the parity disabled are also applied. A design that counted on every clock would drift, and one that cleared parity under `parity_off` would leave the next frame's flag wrong.

// File: rtl/csg_pkg.sv
package csg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_EQ,
        ST_BROAD,
        ST_POST_EQ,
        ST_ACTIVE
    } csg_state_t;

    typedef enum logic [1:0] {
        MODE_INTERLACE = 2'b00,
        MODE_TEXT      = 2'b01,
        MODE_TERMINAL  = 2'b10,
        MODE_EXTSYNC   = 2'b11
    } csg_mode_t;

    // Nearest tick for a time given in hundredths of a microsecond (line = 6400)
    function automatic int ticks_at(input int line_ticks, input int centi_us);
        return (centi_us * line_ticks + 3200) / 6400;
    endfunction

endpackage

// File: rtl/csg_half_counter.sv
module csg_half_counter #(
    parameter int HALF_TICKS = 192,
    parameter int HW         = $clog2(HALF_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    output logic [HW-1:0] hpos,
    output logic          second_half,
    output logic          half_end
);

    localparam logic [HW-1:0] LAST = HW'(HALF_TICKS - 1);

    assign half_end = tick && !clear && (hpos == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hpos        <= '0;
            second_half <= 1'b0;
        end else if (tick) begin
            if (hpos == LAST) begin
                hpos        <= '0;
                second_half <= ~second_half;
            end else begin
                hpos <= hpos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/csg_field_fsm.sv
module csg_field_fsm
    import csg_pkg::*;
#(
    parameter int FRAME_LINES = 625,
    parameter int VS_HALVES   = 5,
    parameter int FW          = $clog2(FRAME_LINES + 2)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_in,
    input  logic       half_end,
    output csg_state_t state,
    output logic       frame_end
);

    localparam logic [FW-1:0] PRE_LAST   = FW'(VS_HALVES - 1);
    localparam logic [FW-1:0] BROAD_LAST = FW'(2 * VS_HALVES - 1);
    localparam logic [FW-1:0] POST_LAST  = FW'(3 * VS_HALVES - 1);
    localparam logic [FW-1:0] MID_LAST   = FW'(FRAME_LINES - 1);
    localparam logic [FW-1:0] SHORT_LAST = FW'(FRAME_LINES - 2);
    localparam logic [FW-1:0] LONG_LAST  = FW'(FRAME_LINES);

    csg_state_t      state_d;
    csg_mode_t       cur_mode;
    logic            field;
    logic [FW-1:0]   fcnt;
    logic [FW-1:0]   field_last;
    logic            field_end;
    logic            ext_req;

    assign ext_req = (mode_in == MODE_EXTSYNC);

    always_comb begin
        unique case (cur_mode)
            MODE_INTERLACE: field_last = MID_LAST;
            MODE_TEXT:      field_last = field ? LONG_LAST : SHORT_LAST;
            MODE_TERMINAL:  field_last = SHORT_LAST;
            MODE_EXTSYNC:   field_last = SHORT_LAST;
        endcase
    end

    assign field_end = half_end && (state == ST_ACTIVE) && (fcnt == field_last);
    assign frame_end = field_end && field;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    if (!ext_req) state_d = ST_PRE_EQ;
            ST_PRE_EQ:  if (half_end && fcnt == PRE_LAST) state_d = ST_BROAD;
            ST_BROAD:   if (half_end && fcnt == BROAD_LAST) state_d = ST_POST_EQ;
            ST_POST_EQ: if (half_end && fcnt == POST_LAST) state_d = ST_ACTIVE;
            ST_ACTIVE:  if (field_end) state_d = (field && ext_req) ? ST_IDLE : ST_PRE_EQ;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_mode <= MODE_EXTSYNC;
            field    <= 1'b0;
            fcnt     <= '0;
        end else begin
            state <= state_d;
            if (state == ST_IDLE) begin
                fcnt     <= '0;
                field    <= 1'b0;
                cur_mode <= csg_mode_t'(mode_in);
            end else if (field_end) begin
                fcnt  <= '0;
                field <= ~field;
                if (field) cur_mode <= csg_mode_t'(mode_in);
            end else if (half_end) begin
                fcnt <= fcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/csg_line_track.sv
module csg_line_track #(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          half_end,
    input  logic          second_half,
    input  logic          frame_end,
    output logic [LW-1:0] line_no,
    output logic          parity
);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            line_no <= LW'(1);
            parity  <= 1'b0;
        end else if (frame_end) begin
            line_no <= LW'(1);
            parity  <= ~parity;
        end else if (half_end && second_half) begin
            line_no <= line_no + 1'b1;
        end
    end

endmodule

// File: rtl/csg_timebase.sv
module csg_timebase
    import csg_pkg::*;
#(
    parameter int LINE_TICKS   = 384,
    parameter int FRAME_LINES  = 625,
    parameter int VS_HALVES    = 5,
    parameter int WIN_A_FIRST  = 42,
    parameter int WIN_A_LAST   = 291,
    parameter int WIN_B_FIRST  = 355,
    parameter int WIN_B_LAST   = 604
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] mode_in,
    input  logic       sync_oe,
    input  logic       parity_off,
    output logic       csync_n,
    output logic       disp_en,
    output logic       odd_even
);

    localparam int HALF_TICKS = LINE_TICKS / 2;
    localparam int HW = $clog2(HALF_TICKS);
    localparam int PW = $clog2(LINE_TICKS);
    localparam int LW = $clog2(FRAME_LINES + 2);

    localparam logic [HW-1:0] LSP_T   = HW'(ticks_at(LINE_TICKS, 466));
    localparam logic [HW-1:0] EQ_T    = HW'(ticks_at(LINE_TICKS, 233));
    localparam logic [HW-1:0] BROAD_T = HW'(ticks_at(LINE_TICKS, 2733));
    localparam logic [PW-1:0] WIN_ON  = PW'(ticks_at(LINE_TICKS, 1667));
    localparam logic [PW-1:0] WIN_OFF = PW'(ticks_at(LINE_TICKS, 5667));
    localparam logic [PW-1:0] HALF_P  = PW'(HALF_TICKS);

    csg_state_t    state;
    logic [HW-1:0] hpos;
    logic          second_half;
    logic          half_end;
    logic          frame_end;
    logic [LW-1:0] line_no;
    logic          parity;
    logic          hl_start;
    logic [PW-1:0] line_pos;
    logic          in_rows;
    logic          pulse_low;
    logic          running;

    assign running  = (state != ST_IDLE);
    assign hl_start = (hpos == '0);

    csg_half_counter #(.HALF_TICKS(HALF_TICKS), .HW(HW)) u_half (
        .clk(clk), .rst_n(rst_n), .clear(!running), .tick(tick),
        .hpos(hpos), .second_half(second_half), .half_end(half_end)
    );

    csg_field_fsm #(.FRAME_LINES(FRAME_LINES), .VS_HALVES(VS_HALVES), .FW(LW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .half_end(half_end),
        .state(state), .frame_end(frame_end)
    );

    csg_line_track #(.LW(LW)) u_line (
        .clk(clk), .rst_n(rst_n), .clear(!running), .half_end(half_end),
        .second_half(second_half), .frame_end(frame_end),
        .line_no(line_no), .parity(parity)
    );

    always_comb begin
        line_pos = second_half ? (HALF_P + PW'(hpos)) : PW'(hpos);
        in_rows  = ((line_no >= LW'(WIN_A_FIRST)) && (line_no <= LW'(WIN_A_LAST))) ||
                   ((line_no >= LW'(WIN_B_FIRST)) && (line_no <= LW'(WIN_B_LAST)));
        unique case (state)
            ST_IDLE:    pulse_low = 1'b0;
            ST_PRE_EQ:  pulse_low = (hpos < EQ_T);
            ST_BROAD:   pulse_low = (hpos < BROAD_T);
            ST_POST_EQ: pulse_low = (hpos < EQ_T);
            ST_ACTIVE:  pulse_low = !second_half && (hpos < LSP_T);
            default:    pulse_low = 1'b0;
        endcase
        csync_n  = !(sync_oe && pulse_low);
        disp_en  = running && in_rows && (line_pos >= WIN_ON) && (line_pos < WIN_OFF);
        odd_even = running && parity && !parity_off;
    end

endmodule

// File: rtl/csg_timebase_chk.sv
module csg_timebase_chk
    import csg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [1:0] mode_in,
    input logic       sync_oe,
    input logic       csync_n,
    input logic       disp_en,
    input logic       hl_start,
    input csg_state_t st
);

    // R2
    sync_fall_on_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(csync_n) && $stable(sync_oe)) |-> hl_start);

    // R9
    window_clear_of_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> csync_n);

    // R3
    pre_eq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PRE_EQ) |=> (st == ST_PRE_EQ || st == ST_BROAD));

    // R4
    broad_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BROAD) |=> (st == ST_BROAD || st == ST_POST_EQ));

    // R5
    post_eq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_POST_EQ) |=> (st == ST_POST_EQ || st == ST_ACTIVE));

    // R6
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && mode_in != 2'b11) |=> (st == ST_PRE_EQ && hl_start));

    // R11
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && st != ST_IDLE) |=> ($stable(st) && $stable(disp_en)));

endmodule

bind csg_timebase csg_timebase_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_in(mode_in), .sync_oe(sync_oe),
    .csync_n(csync_n), .disp_en(disp_en), .hl_start(hl_start), .st(state)
);

// File: tb/csg_timebase_test.sv
`timescale 1ns/1ps
module csg_timebase_test;

    // Bench configuration: 64 ticks per line, so one tick per microsecond
    localparam int LT = 64;
    localparam int HT = 32;
    localparam int LSP = 5;    // round(4.66)
    localparam int EQ = 2;     // round(2.33)
    localparam int BRD = 27;   // round(27.33)
    localparam int WON = 17;   // round(16.67)
    localparam int WOFF = 57;  // round(56.67)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] mode_in = 2'b00;
    logic       sync_oe = 1'b1;
    logic       parity_off = 1'b0;
    logic       csync_n, disp_en, odd_even;

    csg_timebase #(.LINE_TICKS(LT)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_in(mode_in), .sync_oe(sync_oe),
        .parity_off(parity_off), .csync_n(csync_n), .disp_en(disp_en), .odd_even(odd_even)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    bit m_idle = 1;
    int pos = 0;
    int mmode = 0;
    bit mpar = 0;
    int frame = 0;
    int nclk = 0;
    int idle_steps = 0;
    int run_steps = 0;

    int err [7];
    int epos [7];
    int eact [7];
    int eexp [7];

    function automatic int frame_ticks(input int m);
        return (m == 2) ? 1248 * HT : 1250 * HT;
    endfunction

    // cat: 0 line pulse, 1 equalizing, 2 broad
    function automatic void expect_at(input int p, input int m, output bit low,
                                      output int cat, output bit dsp);
        int half, hoff, f0, fh, line, lp;
        half = p / HT;
        hoff = p % HT;
        f0 = (m == 0) ? 625 : 624;
        fh = (half < f0) ? half : half - f0;
        if (fh < 5 || (fh >= 10 && fh < 15)) begin
            low = (hoff < EQ); cat = 1;
        end else if (fh < 10) begin
            low = (hoff < BRD); cat = 2;
        end else begin
            low = ((half % 2) == 0) && (hoff < LSP); cat = 0;
        end
        line = p / LT + 1;
        lp = p % LT;
        dsp = (lp >= WON) && (lp < WOFF) &&
              ((line >= 42 && line <= 291) || (line >= 355 && line <= 604));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic note_err(input int c, input int a, input int e);
        if (err[c] == 0) begin
            epos[c] = pos; eact[c] = a; eexp[c] = e;
        end
        err[c]++;
    endtask

    task automatic report(input string req, input int c, input string what);
        check(err[c] == 0, req,
              $sformatf("%s (%0d mismatches, first at tick %0d, got %0d want %0d)",
                        what, err[c], epos[c], eact[c], eexp[c]),
              err[c], 0);
    endtask

    task automatic clear_err();
        for (int i = 0; i < 7; i++) begin
            err[i] = 0; epos[i] = 0; eact[i] = 0; eexp[i] = 0;
        end
    endtask

    task automatic frame_done(input int f);
        if (f == 0) begin
            report("R2", 0, "line pulses, interlaced frame");
            report("R3", 1, "equalizing pulses, interlaced frame");
            report("R4", 2, "broad pulses, interlaced frame");
            report("R9", 3, "display window, interlaced frame");
            report("R8", 4, "odd_even, interlaced frame");
            report("R10", 5, "sync held high with driver off");
            report("R7", 6, "frame unchanged by mid-frame mode write");
        end else if (f == 1) begin
            report("R11", 6, "text-mode frame under tick gaps");
            report("R8", 4, "odd_even with parity_off window");
            report("R5", 0, "line pulses, 312/313 fields");
            report("R5", 2, "broad pulses, 312/313 fields");
        end else begin
            report("R5", 6, "terminal-mode 312/312 frame");
        end
        clear_err();
    endtask

    task automatic step();
        bit wrapped;
        bit low, dsp, e_cs, e_de, e_oe;
        int cat;
        @(posedge clk);
        nclk++;
        wrapped = 0;
        if (m_idle) begin
            if (mode_in != 2'b11) begin
                m_idle = 0; pos = 0; mmode = mode_in;
            end
        end else if (tick) begin
            pos++;
            if (pos == frame_ticks(mmode)) begin
                wrapped = 1;
                mpar = !mpar;
                if (mode_in == 2'b11) begin
                    m_idle = 1; mpar = 0;
                end else begin
                    mmode = mode_in;
                end
                pos = 0;
            end
        end
        if (wrapped) begin
            frame_done(frame);
            frame++;
        end
        @(negedge clk);
        if (m_idle) begin
            e_cs = 1; e_de = 0; e_oe = 0; cat = 0;
        end else begin
            expect_at(pos, mmode, low, cat, dsp);
            e_cs = sync_oe ? !low : 1'b1;
            e_de = dsp;
            e_oe = mpar && !parity_off;
        end
        if (csync_n !== e_cs) begin
            note_err(cat, csync_n, e_cs);
            if (!sync_oe) note_err(5, csync_n, e_cs);
        end
        if (disp_en !== e_de) note_err(3, disp_en, e_de);
        if (odd_even !== e_oe) note_err(4, odd_even, e_oe);
        if (csync_n !== e_cs || disp_en !== e_de || odd_even !== e_oe)
            note_err(6, {csync_n, disp_en, odd_even}, {e_cs, e_de, e_oe});
    endtask

    task automatic spot_checks();
        if (m_idle) return;
        if (frame == 0) begin
            if (pos == 0) check(csync_n == 1'b0, "R3", "frame opens with equalizing pulse", csync_n, 0);
            if (pos == 19999) check(csync_n == 1'b1, "R5", "end of first interlaced field", csync_n, 1);
            if (pos == 20000) check(csync_n == 1'b0, "R5", "second field opens mid-line", csync_n, 0);
            if (pos == 20170) check(csync_n == 1'b0, "R4", "broad pulse of second field", csync_n, 0);
            if (pos == 2640) check(disp_en == 1'b0, "R9", "line 42 before window", disp_en, 0);
            if (pos == 2641) check(disp_en == 1'b1, "R9", "line 42 window start", disp_en, 1);
            if (pos == 2580) check(disp_en == 1'b0, "R9", "line 41 outside rows", disp_en, 0);
            if (pos == 18616) check(disp_en == 1'b1, "R9", "line 291 last window tick", disp_en, 1);
            if (pos == 30050) check(csync_n == 1'b1, "R10", "driver disabled", csync_n, 1);
        end else if (frame == 1) begin
            if (pos == 10) check(odd_even == 1'b1, "R8", "second frame is even", odd_even, 1);
            if (pos == 1050) check(odd_even == 1'b0, "R8", "parity_off forces low", odd_even, 0);
            if (pos == 19968) check(csync_n == 1'b0, "R5", "text-mode second field at line start", csync_n, 0);
            if (pos == 20140) check(csync_n == 1'b0, "R5", "text-mode broad pulse position", csync_n, 0);
        end else if (frame == 2) begin
            if (pos == 10) check(odd_even == 1'b0, "R8", "third frame is odd", odd_even, 0);
        end
    endtask

    task automatic drive();
        if (frame == 0) begin
            tick = 1'b1;
            mode_in = (pos >= 20000) ? 2'b01 : 2'b00;
            sync_oe = !(pos >= 30000 && pos < 30100);
        end else if (frame == 1) begin
            tick = ((nclk % 16) != 15);
            sync_oe = 1'b1;
            parity_off = (pos >= 1000 && pos < 1100);
            mode_in = (pos >= 20000) ? 2'b10 : 2'b01;
        end else if (frame == 2) begin
            tick = 1'b1;
            parity_off = 1'b0;
            mode_in = (pos >= 20000) ? 2'b11 : 2'b10;
        end else begin
            if (m_idle) begin
                idle_steps++;
                if (idle_steps == 200) begin
                    check(csync_n == 1'b1, "R6", "idle sync level", csync_n, 1);
                    check(disp_en == 1'b0, "R6", "idle display window", disp_en, 0);
                    check(odd_even == 1'b0, "R6", "idle parity output", odd_even, 0);
                    tick = 1'b0;
                    mode_in = 2'b00;
                end
            end else begin
                if (run_steps == 0) begin
                    check(csync_n == 1'b0, "R6", "restart opens with equalizing pulse", csync_n, 0);
                    check(odd_even == 1'b0, "R6", "restart frame is odd", odd_even, 0);
                    tick = 1'b1;
                end
                run_steps++;
                if (run_steps == 3000) begin
                    report("R6", 6, "idle period and restarted frame");
                    finished = 1;
                end
            end
        end
    endtask

    initial begin
        clear_err();
        tick = 1'b1;
        repeat (4) @(negedge clk);
        check(csync_n == 1'b1, "R1", "reset sync level", csync_n, 1);
        check(disp_en == 1'b0, "R1", "reset display window", disp_en, 0);
        check(odd_even == 1'b0, "R1", "reset parity output", odd_even, 0);
        rst_n = 1'b1;
        while (!finished) begin
            step();
            spot_checks();
            drive();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=%0d expected=%0d", frame, 4);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule